// File: doc/BRIEF.md
# Byte-Lane Asynchronous SRAM Sequencer

This block connects a simple synchronous request/acknowledge host port to an external asynchronous static RAM that has a word address, a 16-bit shared data bus and five active-low strobes: chip select, output enable, write strobe, and one enable per byte lane. Each host request becomes one complete memory cycle. The number of clock cycles in every phase of that cycle comes from a parameter. The block drives the shared bus only while a write is under way. It captures read data at the end of the access window. When no request is being served, it returns the memory to standby with chip select high.

A write runs in three phases: an address/data setup phase with chip select low, a write-strobe pulse, and a hold phase in which address and data are still driven. A read holds chip select and output enable low for the access window. It then passes through a recovery phase with the bus released before any later write may drive it. Byte enables of the host map directly to the lane strobes. Host bit 0 selects bits 7:0 and host bit 1 selects bits 15:8. Lanes that were not enabled read back as zero. A request with no lane enabled is acknowledged at once and touches nothing.

The bus is split into an output value, an output-enable and an input value. The pad ring or the testbench resolves the tristate.

Top module: `sram_lane_ctrl`

## Requirements
- R1: While reset is asserted, chip select, output enable, write strobe and both lane enables are high (inactive), the bus is released, ack is low and rdata is zero.
- R2: A write with byte enables `be` holds the write strobe low for exactly T_PULSE cycles, with chip select low and `mem_be_n` equal to the bitwise inverse of `be`. Only the enabled lanes of the addressed word change in the memory: bit 0 is bits 7:0 and bit 1 is bits 15:8.
- R3: A read holds chip select and output enable low with the write strobe high for exactly T_ACCESS cycles. rdata in the ack cycle carries memory data on enabled lanes and zero on lanes whose enable bit is 0.
- R4: The bus is driven only while chip select is low and output enable is high. The block and the memory never drive the bus in the same cycle.
- R5: The write strobe and output enable are never low in the same cycle.
- R6: A write keeps chip select low and drives address and data for T_SETUP cycles before the write strobe falls. Address and data stay stable while the strobe is low, and they remain driven with chip select low for T_HOLD cycles after it rises, so chip select is low for T_SETUP+T_PULSE+T_HOLD cycles in total.
- R7: The memory address is presented no later than the cycle in which chip select falls, and it stays stable for as long as chip select remains low.
- R8: Whenever no transaction is active, chip select is high, both lane enables are high and the bus is released. This holds in the ack cycle of every request.
- R9: A request with `be` equal to 2'b00 is acknowledged in the cycle right after it is accepted. It asserts no strobe and returns rdata equal to zero.
- R10: ack is high for a single cycle. It comes T_SETUP+T_PULSE+T_HOLD edges after the accepting edge for a write and T_ACCESS edges after it for a read.
- R11: After output enable has been low, the bus is not driven in the following cycle. Every read therefore ends with a released-bus cycle before a write drives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Host request, held until ack |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | AW | Word address |
| wdata | input | DW | Write data |
| be | input | DW/8 | Byte-lane enables, bit 0 = bits 7:0 |
| ack | output | 1 | One-cycle completion pulse |
| rdata | output | DW | Read data, valid with ack |
| mem_addr | output | AW | Memory address |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_be_n | output | DW/8 | Lane enables, active low |
| mem_dq_o | output | DW | Value driven onto the bus |
| mem_dq_oe | output | 1 | Bus drive enable |
| mem_dq_i | input | DW | Value read from the bus |

## Verification
The checker watches the pin rules on every cycle: no overlap between write strobe and output enable, drive only inside a write, a released cycle after output enable, stable address while selected, stable data around the write strobe, standby whenever chip select is high, and the single-cycle ack. Only the bench scenarios can show that data actually lands in the right lanes. The bench sweeps every address of a small memory through all lane patterns and reads each word back through full and partial lane masks. It also counts per request how many cycles each strobe is low and measures the ack latency, both against values derived from the phase parameters.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;

   typedef enum logic [2:0] {
      ST_IDLE     = 3'd0,
      ST_WSETUP   = 3'd1,
      ST_WPULSE   = 3'd2,
      ST_WHOLD    = 3'd3,
      ST_RACCESS  = 3'd4,
      ST_RRECOVER = 3'd5
   } ctl_state_t;

   function automatic int max_of(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/sram_lane_timer.sv
module sram_lane_timer #(
   parameter int CW = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   output logic          done
);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load)
         cnt_q <= load_val;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - CW'(1);
   end

   assign done = (cnt_q == '0);

endmodule

// File: rtl/sram_lane_strobe.sv
module sram_lane_strobe
   import sram_lane_pkg::*;
#(
   parameter int LANES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  ctl_state_t       nxt_state,
   input  logic [LANES-1:0] nxt_be,
   output logic             ce_n,
   output logic             oe_n,
   output logic             we_n,
   output logic [LANES-1:0] be_n,
   output logic             dq_oe
);

   logic sel_d, rd_d, wr_d, drv_d;

   always_comb begin
      sel_d = 1'b0;
      rd_d  = 1'b0;
      wr_d  = 1'b0;
      drv_d = 1'b0;
      case (nxt_state)
         ST_WSETUP:  begin sel_d = 1'b1; drv_d = 1'b1; end
         ST_WPULSE:  begin sel_d = 1'b1; drv_d = 1'b1; wr_d = 1'b1; end
         ST_WHOLD:   begin sel_d = 1'b1; drv_d = 1'b1; end
         ST_RACCESS: begin sel_d = 1'b1; rd_d = 1'b1; end
         default:    ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ce_n  <= 1'b1;
         oe_n  <= 1'b1;
         we_n  <= 1'b1;
         dq_oe <= 1'b0;
      end else begin
         ce_n  <= !sel_d;
         oe_n  <= !rd_d;
         we_n  <= !wr_d;
         dq_oe <= drv_d;
      end
   end

   // one lane strobe per byte, each gated by chip select
   for (genvar i = 0; i < LANES; i++) begin : g_lane_strobe
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            be_n[i] <= 1'b1;
         else
            be_n[i] <= !(sel_d && nxt_be[i]);
      end
   end

endmodule

// File: rtl/sram_lane_lanes.sv
module sram_lane_lanes #(
   parameter int LANES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_load,
   input  logic [8*LANES-1:0] host_wdata,
   input  logic               rd_capture,
   input  logic               rd_clear,
   input  logic [LANES-1:0]   lane_en,
   input  logic [8*LANES-1:0] bus_in,
   output logic [8*LANES-1:0] wr_word,
   output logic [8*LANES-1:0] rd_word
);

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      logic [7:0] wr_q;
      logic [7:0] rd_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            wr_q <= '0;
         else if (wr_load)
            wr_q <= host_wdata[8*i +: 8];
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            rd_q <= '0;
         else if (rd_clear)
            rd_q <= '0;
         else if (rd_capture)
            rd_q <= lane_en[i] ? bus_in[8*i +: 8] : 8'h00;
      end

      assign wr_word[8*i +: 8] = wr_q;
      assign rd_word[8*i +: 8] = rd_q;
   end

endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
   import sram_lane_pkg::*;
#(
   parameter int AW       = 18,
   parameter int DW       = 16,
   parameter int T_SETUP  = 1,
   parameter int T_PULSE  = 2,
   parameter int T_HOLD   = 1,
   parameter int T_ACCESS = 2,
   parameter int T_TURN   = 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            req,
   input  logic            we,
   input  logic [AW-1:0]   addr,
   input  logic [DW-1:0]   wdata,
   input  logic [DW/8-1:0] be,
   output logic            ack,
   output logic [DW-1:0]   rdata,
   output logic [AW-1:0]   mem_addr,
   output logic            mem_ce_n,
   output logic            mem_oe_n,
   output logic            mem_we_n,
   output logic [DW/8-1:0] mem_be_n,
   output logic [DW-1:0]   mem_dq_o,
   output logic            mem_dq_oe,
   input  logic [DW-1:0]   mem_dq_i
);

   localparam int LANES = DW / 8;
   localparam int TMAX  = max_of(max_of(max_of(T_SETUP, T_PULSE), max_of(T_HOLD, T_ACCESS)), T_TURN);
   localparam int CW    = $clog2(TMAX + 1);
   localparam logic [CW-1:0] V_SETUP  = CW'(T_SETUP - 1);
   localparam logic [CW-1:0] V_PULSE  = CW'(T_PULSE - 1);
   localparam logic [CW-1:0] V_HOLD   = CW'(T_HOLD - 1);
   localparam logic [CW-1:0] V_ACCESS = CW'(T_ACCESS - 1);
   localparam logic [CW-1:0] V_TURN   = CW'(T_TURN - 1);

   if (T_SETUP < 1 || T_PULSE < 1 || T_HOLD < 1 || T_ACCESS < 1 || T_TURN < 1) begin : g_bad_timing
      $error("sram_lane_ctrl: every phase count must be one cycle or more");
   end
   if (DW < 8 || (DW % 8) != 0) begin : g_bad_width
      $error("sram_lane_ctrl: data width must be a whole number of bytes");
   end
   if (AW < 1) begin : g_bad_addr
      $error("sram_lane_ctrl: address width must be positive");
   end

   ctl_state_t       state_q, state_d;
   logic             tmr_load, tmr_done;
   logic [CW-1:0]    tmr_val;
   logic             ack_q, ack_set;
   logic             rd_capture, rd_clear;
   logic             accept;
   logic [AW-1:0]    addr_q;
   logic [LANES-1:0] be_q, be_src;

   assign accept = (state_q == ST_IDLE) && req && !ack_q && (be != '0);
   assign be_src = accept ? be : be_q;

   always_comb begin
      state_d    = state_q;
      tmr_load   = 1'b0;
      tmr_val    = '0;
      ack_set    = 1'b0;
      rd_capture = 1'b0;
      rd_clear   = 1'b0;
      case (state_q)
         ST_IDLE: begin
            if (req && !ack_q) begin
               if (be == '0) begin
                  ack_set  = 1'b1;
                  rd_clear = 1'b1;
               end else if (we) begin
                  state_d  = ST_WSETUP;
                  tmr_load = 1'b1;
                  tmr_val  = V_SETUP;
               end else begin
                  state_d  = ST_RACCESS;
                  tmr_load = 1'b1;
                  tmr_val  = V_ACCESS;
               end
            end
         end
         ST_WSETUP: begin
            if (tmr_done) begin
               state_d  = ST_WPULSE;
               tmr_load = 1'b1;
               tmr_val  = V_PULSE;
            end
         end
         ST_WPULSE: begin
            if (tmr_done) begin
               state_d  = ST_WHOLD;
               tmr_load = 1'b1;
               tmr_val  = V_HOLD;
            end
         end
         ST_WHOLD: begin
            if (tmr_done) begin
               state_d = ST_IDLE;
               ack_set = 1'b1;
            end
         end
         ST_RACCESS: begin
            if (tmr_done) begin
               state_d    = ST_RRECOVER;
               tmr_load   = 1'b1;
               tmr_val    = V_TURN;
               ack_set    = 1'b1;
               rd_capture = 1'b1;
            end
         end
         ST_RRECOVER: begin
            if (tmr_done)
               state_d = ST_IDLE;
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         ack_q   <= 1'b0;
         addr_q  <= '0;
         be_q    <= '0;
      end else begin
         state_q <= state_d;
         ack_q   <= ack_set;
         if (accept) begin
            addr_q <= addr;
            be_q   <= be;
         end
      end
   end

   sram_lane_timer #(.CW(CW)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .done     (tmr_done)
   );

   sram_lane_strobe #(.LANES(LANES)) u_strobe (
      .clk       (clk),
      .rst_n     (rst_n),
      .nxt_state (state_d),
      .nxt_be    (be_src),
      .ce_n      (mem_ce_n),
      .oe_n      (mem_oe_n),
      .we_n      (mem_we_n),
      .be_n      (mem_be_n),
      .dq_oe     (mem_dq_oe)
   );

   sram_lane_lanes #(.LANES(LANES)) u_lanes (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_load    (accept && we),
      .host_wdata (wdata),
      .rd_capture (rd_capture),
      .rd_clear   (rd_clear),
      .lane_en    (be_q),
      .bus_in     (mem_dq_i),
      .wr_word    (mem_dq_o),
      .rd_word    (rdata)
   );

   assign ack      = ack_q;
   assign mem_addr = addr_q;

endmodule

// File: rtl/sram_lane_ctrl_chk.sv
module sram_lane_ctrl_chk #(
   parameter int AW    = 18,
   parameter int DW    = 16,
   parameter int LANES = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             ack,
   input logic [DW-1:0]    rdata,
   input logic [AW-1:0]    mem_addr,
   input logic             mem_ce_n,
   input logic             mem_oe_n,
   input logic             mem_we_n,
   input logic [LANES-1:0] mem_be_n,
   input logic [DW-1:0]    mem_dq_o,
   input logic             mem_dq_oe
);

   always @(posedge clk) begin
      if (!rst_n) begin
         assert_reset_idle_R1: assert (mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe
                                       && (mem_be_n == '1) && !ack && (rdata == '0));
      end
   end

   assert_drive_in_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
      mem_dq_oe |-> (mem_oe_n && !mem_ce_n));

   assert_no_strobe_overlap_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !(!mem_we_n && !mem_oe_n));

   assert_write_setup_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mem_we_n) |-> ($past(!mem_ce_n) && $past(mem_dq_oe) && $stable(mem_addr) && $stable(mem_dq_o)));

   assert_write_data_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_we_n && $past(!mem_we_n)) |-> ($stable(mem_dq_o) && $stable(mem_addr)));

   assert_write_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_we_n) |-> (!mem_ce_n && mem_dq_oe && $stable(mem_addr) && $stable(mem_dq_o)));

   assert_write_needs_select_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_we_n |-> (!mem_ce_n && mem_dq_oe && (mem_be_n != '1)));

   assert_addr_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));

   assert_standby_R8: assert property (@(posedge clk) disable iff (!rst_n)
      mem_ce_n |-> ((mem_be_n == '1) && mem_we_n && mem_oe_n && !mem_dq_oe));

   assert_selected_has_lane_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_ce_n |-> (mem_be_n != '1));

   assert_ack_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ack |=> !ack);

   assert_turnaround_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(mem_oe_n) |-> !mem_dq_oe);

endmodule

bind sram_lane_ctrl sram_lane_ctrl_chk #(.AW(AW), .DW(DW), .LANES(LANES)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .ack       (ack),
   .rdata     (rdata),
   .mem_addr  (mem_addr),
   .mem_ce_n  (mem_ce_n),
   .mem_oe_n  (mem_oe_n),
   .mem_we_n  (mem_we_n),
   .mem_be_n  (mem_be_n),
   .mem_dq_o  (mem_dq_o),
   .mem_dq_oe (mem_dq_oe)
);

// File: tb/sram_lane_ctrl_test.sv
module sram_lane_ctrl_test;

   localparam int AW = 4;
   localparam int DW = 16;
   localparam int S  = 2;
   localparam int P  = 3;
   localparam int H  = 2;
   localparam int A  = 3;
   localparam int T  = 1;
   localparam int WORDS = 1 << AW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b1;
   logic          req = 1'b0;
   logic          we = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] wdata = '0;
   logic [1:0]    be = '0;
   logic          ack;
   logic [DW-1:0] rdata;
   logic [AW-1:0] mem_addr;
   logic          mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
   logic [1:0]    mem_be_n;
   logic [DW-1:0] mem_dq_o, mem_dq_i;

   int checks = 0;
   int errors = 0;

   always #2 clk = !clk;

   sram_lane_ctrl #(.AW(AW), .DW(DW), .T_SETUP(S), .T_PULSE(P), .T_HOLD(H),
                    .T_ACCESS(A), .T_TURN(T)) uut (
      .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr), .wdata(wdata), .be(be),
      .ack(ack), .rdata(rdata), .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
      .mem_we_n(mem_we_n), .mem_be_n(mem_be_n), .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe),
      .mem_dq_i(mem_dq_i));

   // behavioural memory with per-lane enables; undriven lanes float to A5
   logic [DW-1:0] mem [WORDS];
   logic [DW-1:0] shadow [WORDS];
   logic          mem_live = 1'b0;
   logic          mem_drives;
   logic [DW-1:0] mem_out;

   assign mem_drives = !mem_ce_n && !mem_oe_n && mem_we_n && (mem_be_n != 2'b11);
   assign mem_out[7:0]  = (mem_drives && !mem_be_n[0]) ? mem[mem_addr][7:0]  : 8'hA5;
   assign mem_out[15:8] = (mem_drives && !mem_be_n[1]) ? mem[mem_addr][15:8] : 8'hA5;
   assign mem_dq_i = mem_dq_oe ? mem_dq_o : mem_out;

   always @(posedge mem_we_n) begin
      if (mem_live && mem_ce_n === 1'b0) begin
         if (!mem_be_n[0]) mem[mem_addr][7:0]  = mem_dq_o[7:0];
         if (!mem_be_n[1]) mem[mem_addr][15:8] = mem_dq_o[15:8];
      end
   end

   // pin monitors sampled at the clock edge (values of the finished cycle)
   int cnt_ce = 0, cnt_we = 0, cnt_oe = 0;
   int viol_r4 = 0, viol_r5 = 0, viol_r11 = 0;
   logic prev_oe_low = 1'b0;

   always @(posedge clk) begin
      if (rst_n && mem_live) begin
         if (!mem_ce_n) cnt_ce++;
         if (!mem_we_n) cnt_we++;
         if (!mem_oe_n) cnt_oe++;
         if (mem_dq_oe && (mem_drives || !mem_oe_n || mem_ce_n)) viol_r4++;
         if (!mem_we_n && !mem_oe_n) viol_r5++;
         if (prev_oe_low && mem_dq_oe) viol_r11++;
         prev_oe_low = !mem_oe_n;
      end
   end

   task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic txn(input logic w, input logic [AW-1:0] a, input logic [DW-1:0] d,
                      input logic [1:0] b, output logic [DW-1:0] rd);
      int n, c0, w0, o0, exp_lat, exp_ce, exp_we, exp_oe;
      @(negedge clk);
      req = 1'b1; we = w; addr = a; wdata = d; be = b;
      c0 = cnt_ce; w0 = cnt_we; o0 = cnt_oe;
      n = 0;
      do begin
         @(negedge clk);
         n++;
      end while (!ack && n < 64);
      rd  = rdata;
      req = 1'b0;
      exp_lat = (b == 2'b00) ? 1 : (w ? S + P + H + 1 : A + 1);
      exp_ce  = (b == 2'b00) ? 0 : (w ? S + P + H : A);
      exp_we  = (b != 2'b00 && w) ? P : 0;
      exp_oe  = (b != 2'b00 && !w) ? A : 0;
      check(n == exp_lat, (b == 2'b00) ? "R9 empty ack latency" : "R10 ack latency", n, exp_lat);
      check(cnt_ce - c0 == exp_ce, "R6 chip select low cycles", cnt_ce - c0, exp_ce);
      check(cnt_we - w0 == exp_we, "R2 write strobe cycles", cnt_we - w0, exp_we);
      check(cnt_oe - o0 == exp_oe, "R3 output enable cycles", cnt_oe - o0, exp_oe);
      check(mem_ce_n && mem_we_n && mem_oe_n && mem_be_n == 2'b11 && !mem_dq_oe,
            "R8 standby in ack cycle", {mem_ce_n, mem_we_n, mem_oe_n, mem_be_n, mem_dq_oe}, 6'b111110);
   endtask

   function automatic logic [DW-1:0] lane_mask(input logic [1:0] b);
      return {{8{b[1]}}, {8{b[0]}}};
   endfunction

   function automatic logic [DW-1:0] pattern(input int a, input int k);
      return 16'(((k + 1) * 16'h1357) ^ (a * 16'h0F11));
   endfunction

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL R10 watchdog expired actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [DW-1:0] rd;
      logic [DW-1:0] m;
      for (int i = 0; i < WORDS; i++) begin
         mem[i] = '0;
         shadow[i] = '0;
      end
      #1 rst_n = 1'b0;
      repeat (3) @(negedge clk);
      check(mem_ce_n && mem_oe_n && mem_we_n && mem_be_n == 2'b11 && !mem_dq_oe && !ack,
            "R1 strobes idle in reset", {mem_ce_n, mem_oe_n, mem_we_n, mem_be_n, mem_dq_oe, ack},
            7'b1111100);
      check(rdata == '0, "R1 rdata zero in reset", rdata, 0);
      rst_n = 1'b1;
      mem_live = 1'b1;
      repeat (2) @(negedge clk);

      // fill every word with full-lane writes
      for (int a = 0; a < WORDS; a++) begin
         txn(1'b1, AW'(a), pattern(a, 7), 2'b11, rd);
         shadow[a] = pattern(a, 7);
      end

      // per-address sweep over all lane patterns with readback
      for (int a = 0; a < WORDS; a++) begin
         for (int k = 0; k < 4; k++) begin
            txn(1'b1, AW'(a), pattern(a, k), 2'(k), rd);
            m = lane_mask(2'(k));
            shadow[a] = (shadow[a] & ~m) | (pattern(a, k) & m);
            for (int rb = 0; rb < 4; rb++) begin
               txn(1'b0, AW'(a), '0, 2'(rb), rd);
               if (rb == 0)
                  check(rd == '0, "R9 empty read returns zero", rd, 0);
               else
                  check(rd == (shadow[a] & lane_mask(2'(rb))), "R3 lane readback after R2 write",
                        rd, shadow[a] & lane_mask(2'(rb)));
            end
         end
      end

      // a final pass confirms other addresses were untouched by the sweep
      for (int a = 0; a < WORDS; a++) begin
         txn(1'b0, AW'(a), '0, 2'b11, rd);
         check(rd == shadow[a], "R2 neighbour words intact", rd, shadow[a]);
      end

      repeat (4) @(negedge clk);
      check(viol_r4 == 0, "R4 bus contention or drive outside write", viol_r4, 0);
      check(viol_r5 == 0, "R5 write strobe overlaps output enable", viol_r5, 0);
      check(viol_r11 == 0, "R11 drive right after output enable", viol_r11, 0);
      check(mem_ce_n && !mem_dq_oe, "R8 idle after sweep", {mem_ce_n, mem_dq_oe}, 2'b10);
      check(mem_addr == AW'(WORDS - 1), "R7 address held after last cycle", mem_addr, WORDS - 1);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule